// File: doc/BRIEF.md
# Self-Timed Page Operation Sequencer

This block runs the internal array operations that a serial command frame launches once chip select has gone high. A front end that parses the frame presents an opcode and a page number and pulses `launch_i` for one cycle. The sequencer then walks the page one byte per cycle through a buffer port and a behavioural page-array port. After each walk it holds for a programmable number of cycles that stands in for the transfer, erase or program time. Composite commands are run as a chain of phases. Erase-then-program is two phases, and the page rewrite is transfer, then erase, then program.

While an operation runs, `busy_o` and the open-drain pull enable are high. A compare latches its result flag when it finishes. An active-low write-protect input keeps the lower part of the array from being modified, and the operation still runs its full busy time. Launches that arrive while busy are dropped, and an asynchronous reset aborts whatever is in flight.

Top module: `page_op_seq`

## Requirements
- R1: A launch with a recognised opcode (0x53, 0x60, 0x83, 0x82, 0x88, 0x81, 0x50, 0x58) raises `busy_o` in the next cycle. Any other opcode is ignored: busy stays low and nothing is written.
- R2: Each phase is busy for PAGE_BYTES walk cycles plus (its wait count + 1). Transfer and compare use the transfer count, erase uses the erase count and program uses the program count. A block erase walks eight pages and then waits once. `rdy_busy_pull_o` is high exactly while busy.
- R3: Transfer (0x53) copies all bytes of the addressed page into the buffer.
- R4: Compare (0x60) sets `cmp_diff_o` to 0 when every byte matches and to 1 when any bit differs. The flag changes only when a compare finishes, and it is 0 after reset.
- R5: 0x83 and 0x82 first set the page to 0xFF and then copy the buffer into it. Both phases are timed.
- R6: 0x88 copies the buffer into the page with a single program phase.
- R7: 0x81 sets the addressed page to 0xFF and leaves neighbouring pages untouched.
- R8: 0x50 sets the eight pages {page[8:3], 000} to {page[8:3], 111} to 0xFF. Page bits 2:0 are ignored.
- R9: 0x58 loads the page into the buffer, then erases the page and programs it back. The page ends unchanged and the buffer holds its content.
- R10: While `wp_ni` is low, programs and erases aimed at pages below PROT_PAGES (256) leave those pages unchanged but still run the full busy time. Pages at or above 256 are still written, and a block erase skips only its protected pages.
- R11: A launch while busy is ignored.
- R12: `rst_ni` low drops busy at once and aborts the operation. After release, the next launch runs normally.
- R13: Neither the buffer nor the array sees a write strobe while the block is idle, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | One-cycle start pulse after chip select rises |
| opcode_i | input | 8 | Command opcode |
| page_i | input | 9 | Target page |
| wp_ni | input | 1 | Write protect, active low |
| xfer_cyc_i | input | 16 | Wait count after a transfer or compare walk |
| erase_cyc_i | input | 16 | Wait count after an erase walk |
| prog_cyc_i | input | 16 | Wait count after a program walk |
| busy_o | output | 1 | Operation in progress |
| rdy_busy_pull_o | output | 1 | Pull-down enable for the open-drain ready/busy pin |
| cmp_diff_o | output | 1 | Latched compare result, 1 = mismatch |
| buf_addr_o | output | 9 | Buffer byte address |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data for buf_addr_o |
| arr_page_o | output | 9 | Array page address |
| arr_byte_o | output | 9 | Array byte address |
| arr_we_o | output | 1 | Array write strobe |
| arr_wdata_o | output | 8 | Array write data |
| arr_rdata_i | input | 8 | Array read data for the current address |

## Verification
A phase index or byte counter that goes wrong shows up on the busy length as soon as the operation ends, and on the page content. A wrong block offset leaves one of the eight pages holding its old data, or clobbers a neighbour page. A broken protect decision is visible in the first array write to a low page while `wp_ni` is low. A wrong compare accumulator shows up the moment busy falls, either as a flag that misses a mismatch in the last byte or as a flag that keeps the previous result.

// File: rtl/page_seq_pkg.sv
package page_seq_pkg;
  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_XFER  = 3'd1,
    PH_CMP   = 3'd2,
    PH_ERASE = 3'd3,
    PH_PROG  = 3'd4
  } phase_e;

  typedef struct packed {
    logic   valid;
    logic   block;
    phase_e ph0;
    phase_e ph1;
    phase_e ph2;
  } plan_t;

  localparam logic [7:0] OPC_XFER     = 8'h53;
  localparam logic [7:0] OPC_CMP      = 8'h60;
  localparam logic [7:0] OPC_EPROG    = 8'h83;
  localparam logic [7:0] OPC_LOADPROG = 8'h82;
  localparam logic [7:0] OPC_PROG     = 8'h88;
  localparam logic [7:0] OPC_PERASE   = 8'h81;
  localparam logic [7:0] OPC_BERASE   = 8'h50;
  localparam logic [7:0] OPC_REWRITE  = 8'h58;
endpackage

// File: rtl/page_seq_decode.sv
module page_seq_decode
  import page_seq_pkg::*;
(
  input  logic [7:0] opcode_i,
  output plan_t      plan_o
);
  always_comb begin
    plan_o = '0;
    case (opcode_i)
      OPC_XFER: begin
        plan_o.valid = 1'b1; plan_o.ph0 = PH_XFER;
      end
      OPC_CMP: begin
        plan_o.valid = 1'b1; plan_o.ph0 = PH_CMP;
      end
      OPC_EPROG, OPC_LOADPROG: begin
        plan_o.valid = 1'b1; plan_o.ph0 = PH_ERASE; plan_o.ph1 = PH_PROG;
      end
      OPC_PROG: begin
        plan_o.valid = 1'b1; plan_o.ph0 = PH_PROG;
      end
      OPC_PERASE: begin
        plan_o.valid = 1'b1; plan_o.ph0 = PH_ERASE;
      end
      OPC_BERASE: begin
        plan_o.valid = 1'b1; plan_o.block = 1'b1; plan_o.ph0 = PH_ERASE;
      end
      OPC_REWRITE: begin
        plan_o.valid = 1'b1; plan_o.ph0 = PH_XFER;
        plan_o.ph1 = PH_ERASE; plan_o.ph2 = PH_PROG;
      end
      default: plan_o = '0;
    endcase
  end
endmodule

// File: rtl/page_seq_ctrl.sv
module page_seq_ctrl
  import page_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int BLK_PAGES  = 8,
  parameter int CNT_W      = 16,
  parameter int PG_W       = 9,
  parameter int BY_W       = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  plan_t            plan_i,
  input  logic [PG_W-1:0]  page_i,
  input  logic [CNT_W-1:0] xfer_cyc_i,
  input  logic [CNT_W-1:0] erase_cyc_i,
  input  logic [CNT_W-1:0] prog_cyc_i,
  output logic             busy_o,
  output logic             walk_o,
  output logic             done_o,
  output phase_e           phase_o,
  output logic [PG_W-1:0]  page_o,
  output logic [BY_W-1:0]  byte_o
);
  localparam int BLK_W = $clog2(BLK_PAGES);
  localparam logic [BY_W-1:0]  LAST_BYTE = BY_W'(PAGE_BYTES - 1);
  localparam logic [BLK_W-1:0] LAST_OFF  = BLK_W'(BLK_PAGES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_WAIT} st_e;

  st_e              st_q;
  plan_t            plan_q;
  logic [PG_W-1:0]  page_q;
  logic [1:0]       idx_q;
  logic [BLK_W-1:0] off_q;
  logic [BY_W-1:0]  byte_q;
  logic [CNT_W-1:0] wcnt_q;

  phase_e           cur_ph, nxt_ph;
  logic             last_ph, more_pages;
  logic [CNT_W-1:0] wait_load;

  always_comb begin
    case (idx_q)
      2'd0:    begin cur_ph = plan_q.ph0; nxt_ph = plan_q.ph1; end
      2'd1:    begin cur_ph = plan_q.ph1; nxt_ph = plan_q.ph2; end
      default: begin cur_ph = plan_q.ph2; nxt_ph = PH_NONE;    end
    endcase
  end

  assign last_ph    = (nxt_ph == PH_NONE);
  assign more_pages = plan_q.block && (cur_ph == PH_ERASE) && (off_q != LAST_OFF);

  always_comb begin
    case (cur_ph)
      PH_ERASE: wait_load = erase_cyc_i;
      PH_PROG:  wait_load = prog_cyc_i;
      default:  wait_load = xfer_cyc_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      plan_q <= '0;
      page_q <= '0;
      idx_q  <= '0;
      off_q  <= '0;
      byte_q <= '0;
      wcnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (launch_i && plan_i.valid) begin
            plan_q <= plan_i;
            page_q <= page_i;
            idx_q  <= '0;
            off_q  <= '0;
            byte_q <= '0;
            st_q   <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (byte_q == LAST_BYTE) begin
            byte_q <= '0;
            if (more_pages) begin
              off_q <= off_q + 1'b1;
            end else begin
              wcnt_q <= wait_load;
              st_q   <= ST_WAIT;
            end
          end else begin
            byte_q <= byte_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (wcnt_q == '0) begin
            if (last_ph) begin
              st_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              off_q <= '0;
              st_q  <= ST_WALK;
            end
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign walk_o  = (st_q == ST_WALK);
  assign done_o  = (st_q == ST_WAIT) && (wcnt_q == '0) && last_ph;
  assign phase_o = busy_o ? cur_ph : PH_NONE;
  assign byte_o  = byte_q;
  // block erase replaces the low page bits with the walk offset
  assign page_o  = plan_q.block ? {page_q[PG_W-1:BLK_W], off_q} : page_q;
endmodule

// File: rtl/page_seq_dpath.sv
module page_seq_dpath
  import page_seq_pkg::*;
#(
  parameter int PROT_PAGES = 256,
  parameter int PG_W       = 9,
  parameter int BY_W       = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            walk_i,
  input  logic            done_i,
  input  phase_e          phase_i,
  input  logic [PG_W-1:0] page_i,
  input  logic [BY_W-1:0] byte_i,
  input  logic            wp_ni,
  input  logic [7:0]      arr_rdata_i,
  input  logic [7:0]      buf_rdata_i,
  output logic [BY_W-1:0] buf_addr_o,
  output logic            buf_we_o,
  output logic [7:0]      buf_wdata_o,
  output logic [PG_W-1:0] arr_page_o,
  output logic [BY_W-1:0] arr_byte_o,
  output logic            arr_we_o,
  output logic [7:0]      arr_wdata_o,
  output logic            cmp_diff_o
);
  localparam logic [PG_W:0] PROT_LIM = (PG_W+1)'(PROT_PAGES);

  logic prot, byte_diff, diff_q, cmp_q;

  assign prot      = !wp_ni && ({1'b0, page_i} < PROT_LIM);
  assign byte_diff = (arr_rdata_i != buf_rdata_i);

  always_comb begin
    arr_page_o  = walk_i ? page_i : '0;
    arr_byte_o  = walk_i ? byte_i : '0;
    buf_addr_o  = walk_i ? byte_i : '0;
    arr_we_o    = 1'b0;
    arr_wdata_o = '0;
    buf_we_o    = 1'b0;
    buf_wdata_o = '0;
    if (walk_i) begin
      case (phase_i)
        PH_XFER: begin
          buf_we_o    = 1'b1;
          buf_wdata_o = arr_rdata_i;
        end
        PH_ERASE: begin
          arr_we_o    = !prot;
          arr_wdata_o = 8'hFF;
        end
        PH_PROG: begin
          arr_we_o    = !prot;
          arr_wdata_o = buf_rdata_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diff_q <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      if (walk_i && phase_i == PH_CMP)
        diff_q <= ((byte_i == '0) ? 1'b0 : diff_q) | byte_diff;
      if (done_i && phase_i == PH_CMP)
        cmp_q <= diff_q;
    end
  end

  assign cmp_diff_o = cmp_q;
endmodule

// File: rtl/page_op_seq.sv
module page_op_seq
  import page_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int N_PAGES    = 512,
  parameter int PROT_PAGES = 256,
  parameter int BLK_PAGES  = 8,
  parameter int CNT_W      = 16,
  localparam int PG_W      = $clog2(N_PAGES),
  localparam int BY_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [7:0]       opcode_i,
  input  logic [PG_W-1:0]  page_i,
  input  logic             wp_ni,
  input  logic [CNT_W-1:0] xfer_cyc_i,
  input  logic [CNT_W-1:0] erase_cyc_i,
  input  logic [CNT_W-1:0] prog_cyc_i,
  output logic             busy_o,
  output logic             rdy_busy_pull_o,
  output logic             cmp_diff_o,
  output logic [BY_W-1:0]  buf_addr_o,
  output logic             buf_we_o,
  output logic [7:0]       buf_wdata_o,
  input  logic [7:0]       buf_rdata_i,
  output logic [PG_W-1:0]  arr_page_o,
  output logic [BY_W-1:0]  arr_byte_o,
  output logic             arr_we_o,
  output logic [7:0]       arr_wdata_o,
  input  logic [7:0]       arr_rdata_i
);
  plan_t           plan;
  logic            walk, done;
  phase_e          phase;
  logic [PG_W-1:0] cur_page;
  logic [BY_W-1:0] cur_byte;

  page_seq_decode u_dec (
    .opcode_i (opcode_i),
    .plan_o   (plan)
  );

  page_seq_ctrl #(
    .PAGE_BYTES (PAGE_BYTES),
    .BLK_PAGES  (BLK_PAGES),
    .CNT_W      (CNT_W),
    .PG_W       (PG_W),
    .BY_W       (BY_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch_i),
    .plan_i      (plan),
    .page_i      (page_i),
    .xfer_cyc_i  (xfer_cyc_i),
    .erase_cyc_i (erase_cyc_i),
    .prog_cyc_i  (prog_cyc_i),
    .busy_o      (busy_o),
    .walk_o      (walk),
    .done_o      (done),
    .phase_o     (phase),
    .page_o      (cur_page),
    .byte_o      (cur_byte)
  );

  page_seq_dpath #(
    .PROT_PAGES (PROT_PAGES),
    .PG_W       (PG_W),
    .BY_W       (BY_W)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .walk_i      (walk),
    .done_i      (done),
    .phase_i     (phase),
    .page_i      (cur_page),
    .byte_i      (cur_byte),
    .wp_ni       (wp_ni),
    .arr_rdata_i (arr_rdata_i),
    .buf_rdata_i (buf_rdata_i),
    .buf_addr_o  (buf_addr_o),
    .buf_we_o    (buf_we_o),
    .buf_wdata_o (buf_wdata_o),
    .arr_page_o  (arr_page_o),
    .arr_byte_o  (arr_byte_o),
    .arr_we_o    (arr_we_o),
    .arr_wdata_o (arr_wdata_o),
    .cmp_diff_o  (cmp_diff_o)
  );

  assign rdy_busy_pull_o = busy_o;
endmodule

// File: rtl/page_op_seq_chk.sv
module page_op_seq_chk #(
  parameter int N_PAGES    = 512,
  parameter int PROT_PAGES = 256,
  parameter int PG_W       = 9
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            launch_i,
  input logic            wp_ni,
  input logic            busy_o,
  input logic            cmp_diff_o,
  input logic            buf_we_o,
  input logic            arr_we_o,
  input logic [PG_W-1:0] arr_page_o
);
  localparam logic [PG_W:0] LIM = (PG_W+1)'(PROT_PAGES);

  assert_start_needs_launch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(launch_i));

  assert_cmp_moves_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp_diff_o) |-> $fell(busy_o));

  assert_protect_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && !wp_ni) |-> ({1'b0, arr_page_o} >= LIM));

  assert_reset_idle_R12: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o);

  assert_idle_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!arr_we_o && !buf_we_o));

  assert_one_strobe_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_we_o && buf_we_o));
endmodule

bind page_op_seq page_op_seq_chk #(
  .N_PAGES    (N_PAGES),
  .PROT_PAGES (PROT_PAGES),
  .PG_W       (PG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .launch_i   (launch_i),
  .wp_ni      (wp_ni),
  .busy_o     (busy_o),
  .cmp_diff_o (cmp_diff_o),
  .buf_we_o   (buf_we_o),
  .arr_we_o   (arr_we_o),
  .arr_page_o (arr_page_o)
);

// File: tb/sim_page_op_seq.sv
module sim_page_op_seq;
  localparam int PB = 264;
  localparam int NP = 512;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        launch_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [8:0]  page_i = '0;
  logic        wp_ni = 1'b1;
  logic [15:0] xfer_cyc_i = 16'd3, erase_cyc_i = 16'd5, prog_cyc_i = 16'd4;
  logic        busy_o, rdy_busy_pull_o, cmp_diff_o, buf_we_o, arr_we_o;
  logic [8:0]  buf_addr_o, arr_page_o, arr_byte_o;
  logic [7:0]  buf_wdata_o, arr_wdata_o;
  logic [7:0]  buf_rdata_i = '0, arr_rdata_i = '0;

  always #2 clk = ~clk;

  page_op_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .launch_i(launch_i), .opcode_i(opcode_i),
    .page_i(page_i), .wp_ni(wp_ni), .xfer_cyc_i(xfer_cyc_i),
    .erase_cyc_i(erase_cyc_i), .prog_cyc_i(prog_cyc_i), .busy_o(busy_o),
    .rdy_busy_pull_o(rdy_busy_pull_o), .cmp_diff_o(cmp_diff_o),
    .buf_addr_o(buf_addr_o), .buf_we_o(buf_we_o), .buf_wdata_o(buf_wdata_o),
    .buf_rdata_i(buf_rdata_i), .arr_page_o(arr_page_o), .arr_byte_o(arr_byte_o),
    .arr_we_o(arr_we_o), .arr_wdata_o(arr_wdata_o), .arr_rdata_i(arr_rdata_i)
  );

  logic [7:0] amem [int];
  logic [7:0] emem [int];
  logic [7:0] bmem [PB];
  logic [7:0] ebuf [PB];
  logic       ecmp = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic [7:0] init_pat(int p, int b);
    return 8'((p * 37 + b * 11) ^ (p >> 3));
  endfunction
  function automatic logic [7:0] a_rd(int p, int b);
    if (amem.exists(p * 512 + b)) return amem[p * 512 + b];
    return init_pat(p, b);
  endfunction
  function automatic logic [7:0] e_rd(int p, int b);
    if (emem.exists(p * 512 + b)) return emem[p * 512 + b];
    return init_pat(p, b);
  endfunction

  // memories: read at negedge, write late in the same cycle
  always @(negedge clk) begin
    arr_rdata_i = a_rd(int'(arr_page_o), int'(arr_byte_o));
    buf_rdata_i = (int'(buf_addr_o) < PB) ? bmem[buf_addr_o] : 8'h00;
    #1;
    if (arr_we_o) amem[int'(arr_page_o) * 512 + int'(arr_byte_o)] = arr_wdata_o;
    if (buf_we_o && int'(buf_addr_o) < PB) bmem[buf_addr_o] = buf_wdata_o;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_page(int p, string req);
    int bad = -1;
    if (p < 0 || p >= NP) return;
    for (int b = 0; b < PB; b++)
      if (bad < 0 && a_rd(p, b) != e_rd(p, b)) bad = b;
    chk(bad < 0, req, $sformatf("page %0d byte %0d", p, bad),
        (bad < 0) ? 0 : int'(a_rd(p, bad)), (bad < 0) ? 0 : int'(e_rd(p, bad)));
  endtask

  task automatic check_buf(string req);
    int bad = -1;
    for (int b = 0; b < PB; b++)
      if (bad < 0 && bmem[b] != ebuf[b]) bad = b;
    chk(bad < 0, req, $sformatf("buffer byte %0d", bad),
        (bad < 0) ? 0 : int'(bmem[bad]), (bad < 0) ? 0 : int'(ebuf[bad]));
  endtask

  function automatic int exp_busy(logic [7:0] op);
    int wx = int'(xfer_cyc_i), we = int'(erase_cyc_i), wp = int'(prog_cyc_i);
    case (op)
      8'h53, 8'h60: return PB + wx + 1;
      8'h83, 8'h82: return 2 * PB + we + wp + 2;
      8'h88:        return PB + wp + 1;
      8'h81:        return PB + we + 1;
      8'h50:        return 8 * PB + we + 1;
      8'h58:        return 3 * PB + wx + we + wp + 3;
      default:      return 0;
    endcase
  endfunction

  task automatic model(logic [7:0] op, int pg, bit wp);
    bit prot;
    int base;
    prot = !wp && pg < 256;
    base = pg & ~7;
    case (op)
      8'h53: for (int b = 0; b < PB; b++) ebuf[b] = e_rd(pg, b);
      8'h60: begin
        ecmp = 1'b0;
        for (int b = 0; b < PB; b++) if (e_rd(pg, b) != ebuf[b]) ecmp = 1'b1;
      end
      8'h83, 8'h82, 8'h88:
        if (!prot) for (int b = 0; b < PB; b++) emem[pg * 512 + b] = ebuf[b];
      8'h81:
        if (!prot) for (int b = 0; b < PB; b++) emem[pg * 512 + b] = 8'hFF;
      8'h50:
        for (int i = 0; i < 8; i++)
          if (wp || base + i >= 256)
            for (int b = 0; b < PB; b++) emem[(base + i) * 512 + b] = 8'hFF;
      8'h58: begin
        for (int b = 0; b < PB; b++) ebuf[b] = e_rd(pg, b);
        if (!prot) for (int b = 0; b < PB; b++) emem[pg * 512 + b] = ebuf[b];
      end
      default: ;
    endcase
  endtask

  task automatic run_op(logic [7:0] op, int pg, bit wp, string req);
    int n = 0;
    bit pull_ok = 1;
    int base = pg & ~7;
    @(negedge clk);
    opcode_i = op; page_i = 9'(pg); wp_ni = wp; launch_i = 1'b1;
    @(negedge clk);
    launch_i = 1'b0;
    while (busy_o && n < 5000) begin
      if (!rdy_busy_pull_o) pull_ok = 0;
      n++;
      @(negedge clk);
    end
    chk(n == exp_busy(op), "R2", $sformatf("busy cycles op %0h", op), n, exp_busy(op));
    chk(pull_ok, "R2", "pull enable while busy", int'(pull_ok), 1);
    model(op, pg, wp);
    chk(cmp_diff_o == ecmp, "R4", "compare flag", int'(cmp_diff_o), int'(ecmp));
    check_buf(req);
    if (op == 8'h50) begin
      for (int i = -1; i <= 8; i++) check_page(base + i, req);
    end else begin
      check_page(pg, req);
      check_page(pg ^ 1, req);
    end
    chk(!arr_we_o && !buf_we_o, "R13", "strobes when idle", int'(arr_we_o), 0);
  endtask

  task automatic fill_buf(int seed);
    for (int b = 0; b < PB; b++) begin
      bmem[b] = 8'($urandom() ^ seed);
      ebuf[b] = bmem[b];
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] ops [9] = '{8'h53, 8'h60, 8'h83, 8'h82, 8'h88, 8'h81, 8'h50, 8'h58, 8'h52};
    void'($urandom(32'd7321));
    fill_buf(8'h3C);
    repeat (3) @(negedge clk);
    chk(!busy_o && !rdy_busy_pull_o, "R1", "busy in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cmp_diff_o == 1'b0, "R4", "flag after reset", int'(cmp_diff_o), 0);
    chk(!arr_we_o && !buf_we_o, "R13", "strobes after reset", int'(arr_we_o), 0);

    run_op(8'h53, 5, 1, "R3");
    run_op(8'h60, 5, 1, "R4");
    bmem[PB-1] ^= 8'h01; ebuf[PB-1] ^= 8'h01;
    run_op(8'h60, 5, 1, "R4");
    fill_buf(8'h11);
    run_op(8'h83, 270, 1, "R5");
    fill_buf(8'h22);
    run_op(8'h82, 271, 1, "R5");
    run_op(8'h81, 12, 1, "R7");
    fill_buf(8'h33);
    run_op(8'h88, 13, 1, "R6");
    run_op(8'h50, 421, 1, "R8");
    fill_buf(8'h44);
    run_op(8'h58, 40, 1, "R9");
    run_op(8'h81, 100, 0, "R10");
    run_op(8'h83, 300, 0, "R10");
    run_op(8'h50, 8, 0, "R10");
    run_op(8'h50, 250, 0, "R10");
    run_op(8'h52, 60, 1, "R1");

    // R11: second launch during busy is dropped
    @(negedge clk);
    opcode_i = 8'h81; page_i = 9'd310; wp_ni = 1'b1; launch_i = 1'b1;
    @(negedge clk);
    launch_i = 1'b0;
    repeat (20) @(negedge clk);
    page_i = 9'd311; launch_i = 1'b1;
    @(negedge clk);
    launch_i = 1'b0;
    n = 21;
    while (busy_o && n < 5000) begin n++; @(negedge clk); end
    chk(n == exp_busy(8'h81), "R11", "busy length with extra launch", n, exp_busy(8'h81));
    model(8'h81, 310, 1);
    check_page(310, "R11");
    check_page(311, "R11");

    // R12: abort by reset
    @(negedge clk);
    opcode_i = 8'h88; page_i = 9'd430; launch_i = 1'b1;
    @(negedge clk);
    launch_i = 1'b0;
    repeat (30) @(negedge clk);
    rst_ni = 1'b0;
    #0.5;
    chk(!busy_o && !rdy_busy_pull_o, "R12", "busy during reset", int'(busy_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int b = 0; b < PB; b++) emem[430 * 512 + b] = a_rd(430, b);
    ecmp = 1'b0;
    @(negedge clk);
    chk(!busy_o, "R12", "idle after reset", int'(busy_o), 0);
    run_op(8'h81, 431, 1, "R12");

    // constrained random mix
    for (int i = 0; i < 24; i++) begin
      logic [7:0] op;
      op = ops[$urandom_range(0, 8)];
      xfer_cyc_i  = 16'($urandom_range(0, 15));
      erase_cyc_i = 16'($urandom_range(0, 15));
      prog_cyc_i  = 16'($urandom_range(0, 15));
      if ($urandom_range(0, 2) == 0) fill_buf(i);
      run_op(op, $urandom_range(0, NP - 1), 1'($urandom_range(0, 1)), "R10");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule